// File: doc/BRIEF.md
# Flagged Character I/O Port with Interrupt Request

This block sits between a simple processor and two byte-wide character devices, one that produces input and one that consumes output. Each direction has an 8-bit holding register and a ready flag. The input flag shows that an unread byte is waiting for the processor. The output flag shows that the output register is free for a new byte. The two flags protect their registers in opposite senses. The input register is locked while its flag is 1. The output register is locked while its flag is 0.

An access to a locked register is dropped without effect on the register. The drop is recorded in a sticky error bit, and the processor clears both error bits with a single command. An interrupt request is raised while interrupts are enabled and either device is ready. This lets a service routine poll the two flags and move one byte in each direction.

Top module: `char_io_port`

## Requirements
- R1: After reset, in_ready_o is 0, out_ready_o is 1, irq_en_o is 0, irq_o is 0, both error bits are 0, and both data outputs are 0x00.
- R2: When in_ready_o is 0, a cycle with dev_in_strobe_i high stores dev_in_data_i. From the next cycle, the stored byte appears on cpu_in_data_o and in_ready_o is 1.
- R3: When in_ready_o is 1 and cpu_take_i is low, a dev_in_strobe_i leaves cpu_in_data_o and in_ready_o unchanged and sets in_refused_o to 1.
- R4: A cycle with cpu_take_i high and no device strobe makes in_ready_o 0 from the next cycle.
- R5: When cpu_take_i and dev_in_strobe_i are high in the same cycle, the take is handled first. The new byte is stored, in_ready_o remains 1, and in_refused_o does not change.
- R6: When out_ready_o is 1, a cycle with cpu_wr_i high stores cpu_wr_data_i. From the next cycle, the byte appears on dev_out_data_o and out_ready_o is 0.
- R7: When out_ready_o is 0, a cpu_wr_i leaves dev_out_data_o unchanged and sets out_refused_o to 1. This holds even if dev_out_accept_i is high in the same cycle.
- R8: When out_ready_o is 0, dev_out_accept_i makes out_ready_o 1 from the next cycle. When out_ready_o is already 1, dev_out_accept_i has no effect.
- R9: irq_o equals irq_en_o AND (in_ready_o OR out_ready_o) in every cycle.
- R10: irq_en_set_i sets irq_en_o and irq_en_clr_i clears it, both from the next cycle. If both are high in the same cycle, the clear wins.
- R11: err_clr_i clears both error bits from the next cycle. If a refusal happens in the same cycle, the bit for that refusal ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_in_strobe_i | input | 1 | Input device deposits a byte |
| dev_in_data_i | input | 8 | Byte from the input device |
| cpu_take_i | input | 1 | Processor takes the input byte |
| cpu_in_data_o | output | 8 | Input holding register |
| cpu_wr_i | input | 1 | Processor writes an output byte |
| cpu_wr_data_i | input | 8 | Byte written by the processor |
| dev_out_accept_i | input | 1 | Output device has consumed the byte |
| dev_out_data_o | output | 8 | Output holding register |
| irq_en_set_i | input | 1 | Enable interrupts |
| irq_en_clr_i | input | 1 | Disable interrupts |
| err_clr_i | input | 1 | Clear both error bits |
| in_ready_o | output | 1 | Input byte waiting |
| out_ready_o | output | 1 | Output register free |
| irq_en_o | output | 1 | Interrupt enable state |
| irq_o | output | 1 | Interrupt request |
| in_refused_o | output | 1 | Sticky: a device write was dropped |
| out_refused_o | output | 1 | Sticky: a processor write was dropped |

## Verification
Several pairs of functions can coincide in one cycle.

- A processor take can meet a device deposit. The bench drives both strobes on the same cycle while a byte is held. It expects the new byte to be stored, the flag to stay 1, and no error to be recorded.
- A device accept can meet a refused processor write. The bench expects the flag to return to 1 while the old byte is kept and the error bit is set.
- An error clear can meet a fresh refusal. The bench expects the refusal to win.
- An enable set can meet an enable clear. The bench expects the clear to win.

A reference model in the bench predicts every output after each stimulus cycle. A scoreboard compares the prediction with the ports one cycle later.

// File: rtl/char_io_pkg.sv
package char_io_pkg;
  localparam int unsigned CIO_DATA_W = 8;

  typedef enum logic [1:0] {
    EN_KEEP = 2'd0,
    EN_SET  = 2'd1,
    EN_CLR  = 2'd2
  } en_cmd_e;
endpackage

// File: rtl/cio_in_chan.sv
module cio_in_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_strobe_i,
  input  logic [DATA_W-1:0] dev_data_i,
  input  logic              take_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              refused_o
);
  logic load, refuse;

  // take is resolved before the device write in the same cycle
  assign load   = dev_strobe_i & (~full_o | take_i);
  assign refuse = dev_strobe_i & full_o & ~take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      full_o    <= 1'b0;
      refused_o <= 1'b0;
    end else begin
      if (load) begin
        data_o <= dev_data_i;
        full_o <= 1'b1;
      end else if (take_i) begin
        full_o <= 1'b0;
      end
      if (refuse)         refused_o <= 1'b1;
      else if (err_clr_i) refused_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cio_out_chan.sv
module cio_out_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              accept_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              refused_o
);
  logic load, refuse;

  assign load   = wr_i & ready_o;
  assign refuse = wr_i & ~ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      ready_o   <= 1'b1;
      refused_o <= 1'b0;
    end else begin
      if (load) begin
        data_o  <= wr_data_i;
        ready_o <= 1'b0;
      end else if (accept_i) begin
        ready_o <= 1'b1;
      end
      if (refuse)         refused_o <= 1'b1;
      else if (err_clr_i) refused_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cio_irq_ctrl.sv
module cio_irq_ctrl
  import char_io_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic in_full_i,
  input  logic out_ready_i,
  output logic en_o,
  output logic irq_o
);
  en_cmd_e cmd;

  always_comb begin
    if (clr_i)      cmd = EN_CLR;
    else if (set_i) cmd = EN_SET;
    else            cmd = EN_KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b0;
    else begin
      case (cmd)
        EN_SET:  en_o <= 1'b1;
        EN_CLR:  en_o <= 1'b0;
        default: en_o <= en_o;
      endcase
    end
  end

  assign irq_o = en_o & (in_full_i | out_ready_i);
endmodule

// File: rtl/char_io_port.sv
module char_io_port #(
  parameter int unsigned DATA_W = char_io_pkg::CIO_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_in_strobe_i,
  input  logic [DATA_W-1:0] dev_in_data_i,
  input  logic              cpu_take_i,
  output logic [DATA_W-1:0] cpu_in_data_o,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wr_data_i,
  input  logic              dev_out_accept_i,
  output logic [DATA_W-1:0] dev_out_data_o,
  input  logic              irq_en_set_i,
  input  logic              irq_en_clr_i,
  input  logic              err_clr_i,
  output logic              in_ready_o,
  output logic              out_ready_o,
  output logic              irq_en_o,
  output logic              irq_o,
  output logic              in_refused_o,
  output logic              out_refused_o
);
  cio_in_chan #(.DATA_W(DATA_W)) i_in_chan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dev_strobe_i(dev_in_strobe_i),
    .dev_data_i  (dev_in_data_i),
    .take_i      (cpu_take_i),
    .err_clr_i   (err_clr_i),
    .data_o      (cpu_in_data_o),
    .full_o      (in_ready_o),
    .refused_o   (in_refused_o)
  );

  cio_out_chan #(.DATA_W(DATA_W)) i_out_chan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cpu_wr_i),
    .wr_data_i (cpu_wr_data_i),
    .accept_i  (dev_out_accept_i),
    .err_clr_i (err_clr_i),
    .data_o    (dev_out_data_o),
    .ready_o   (out_ready_o),
    .refused_o (out_refused_o)
  );

  cio_irq_ctrl i_irq_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (irq_en_set_i),
    .clr_i      (irq_en_clr_i),
    .in_full_i  (in_ready_o),
    .out_ready_i(out_ready_o),
    .en_o       (irq_en_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/char_io_port_chk.sv
module char_io_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dev_in_strobe_i,
  input logic [DATA_W-1:0] dev_in_data_i,
  input logic              cpu_take_i,
  input logic [DATA_W-1:0] cpu_in_data_o,
  input logic              cpu_wr_i,
  input logic [DATA_W-1:0] cpu_wr_data_i,
  input logic              dev_out_accept_i,
  input logic [DATA_W-1:0] dev_out_data_o,
  input logic              irq_en_set_i,
  input logic              irq_en_clr_i,
  input logic              err_clr_i,
  input logic              in_ready_o,
  input logic              out_ready_o,
  input logic              irq_en_o,
  input logic              irq_o,
  input logic              in_refused_o,
  input logic              out_refused_o
);
  AST_IN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_in_strobe_i && (!in_ready_o || cpu_take_i) |=> in_ready_o && cpu_in_data_o == $past(dev_in_data_i)); // R2
  AST_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && dev_in_strobe_i && !cpu_take_i |=> in_ready_o && $stable(cpu_in_data_o) && in_refused_o); // R3
  AST_TAKE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_take_i && !dev_in_strobe_i |=> !in_ready_o); // R4
  AST_TAKE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_take_i && dev_in_strobe_i && !err_clr_i |=> $stable(in_refused_o)); // R5
  AST_OUT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ready_o && cpu_wr_i |=> !out_ready_o && dev_out_data_o == $past(cpu_wr_data_i)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_ready_o && cpu_wr_i |=> $stable(dev_out_data_o) && out_refused_o); // R7
  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_ready_o && dev_out_accept_i |=> out_ready_o); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_o && (in_ready_o || out_ready_o)); // R9
  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_clr_i |=> !irq_en_o); // R10
  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_set_i && !irq_en_clr_i |=> irq_en_o); // R10
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !dev_in_strobe_i && !cpu_wr_i |=> !in_refused_o && !out_refused_o); // R11
endmodule

bind char_io_port char_io_port_chk #(.DATA_W(DATA_W)) i_char_io_port_chk (.*);

// File: tb/test_char_io_port.sv
module test_char_io_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dev_in_strobe = 1'b0;
  logic [7:0] dev_in_data = '0;
  logic       cpu_take = 1'b0;
  logic [7:0] cpu_in_data;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wr_data = '0;
  logic       dev_out_accept = 1'b0;
  logic [7:0] dev_out_data;
  logic       en_set = 1'b0, en_clr = 1'b0, err_clr = 1'b0;
  logic       in_ready, out_ready, irq_en, irq, in_ref, out_ref;

  always #10 clk = ~clk;

  char_io_port i_char_io_port (
    .clk_i(clk), .rst_ni(rst_n),
    .dev_in_strobe_i(dev_in_strobe), .dev_in_data_i(dev_in_data),
    .cpu_take_i(cpu_take), .cpu_in_data_o(cpu_in_data),
    .cpu_wr_i(cpu_wr), .cpu_wr_data_i(cpu_wr_data),
    .dev_out_accept_i(dev_out_accept), .dev_out_data_o(dev_out_data),
    .irq_en_set_i(en_set), .irq_en_clr_i(en_clr), .err_clr_i(err_clr),
    .in_ready_o(in_ready), .out_ready_o(out_ready), .irq_en_o(irq_en),
    .irq_o(irq), .in_refused_o(in_ref), .out_refused_o(out_ref)
  );

  typedef struct packed {
    logic       in_rdy;
    logic       out_rdy;
    logic       en;
    logic       irq;
    logic       in_ref;
    logic       out_ref;
    logic [7:0] in_data;
    logic [7:0] out_data;
  } snap_t;

  snap_t exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state (from requirements)
  logic       m_in = 1'b0, m_out = 1'b1, m_en = 1'b0, m_iref = 1'b0, m_oref = 1'b0;
  logic [7:0] m_idata = '0, m_odata = '0;

  function automatic snap_t model_snap();
    snap_t s;
    s.in_rdy = m_in; s.out_rdy = m_out; s.en = m_en;
    s.irq = m_en & (m_in | m_out);
    s.in_ref = m_iref; s.out_ref = m_oref;
    s.in_data = m_idata; s.out_data = m_odata;
    return s;
  endfunction

  task automatic step(input string tag, input bit ds, input logic [7:0] dd, input bit tk,
                      input bit wr, input logic [7:0] wd, input bit acc,
                      input bit es, input bit ec, input bit erc);
    logic n_in, n_out, n_iref, n_oref;
    @(negedge clk); #1;
    dev_in_strobe = ds; dev_in_data = dd; cpu_take = tk;
    cpu_wr = wr; cpu_wr_data = wd; dev_out_accept = acc;
    en_set = es; en_clr = ec; err_clr = erc;
    n_in = m_in; n_iref = erc ? 1'b0 : m_iref;
    if (ds && (!m_in || tk)) begin n_in = 1'b1; m_idata = dd; end
    else if (ds) n_iref = 1'b1;
    else if (tk) n_in = 1'b0;
    n_out = m_out; n_oref = erc ? 1'b0 : m_oref;
    if (wr && m_out) begin n_out = 1'b0; m_odata = wd; end
    else begin
      if (wr) n_oref = 1'b1;
      if (acc) n_out = 1'b1;
    end
    if (ec) m_en = 1'b0; else if (es) m_en = 1'b1;
    m_in = n_in; m_out = n_out; m_iref = n_iref; m_oref = n_oref;
    exp_q.push_back(model_snap());
    tag_q.push_back(tag);
  endtask

  // monitor: compare one cycle after each stimulus
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      snap_t e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {in_ready, out_ready, irq_en, irq, in_ref, out_ref, cpu_in_data, dev_out_data};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected < 5000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //   tag   ds dd     tk wr wd    acc es ec erc
    step("R1", 0, 8'h00, 0, 0, 8'h00, 0, 0, 0, 0);
    step("R2", 1, 8'hA5, 0, 0, 8'h00, 0, 0, 0, 0);
    step("R3", 1, 8'h3C, 0, 0, 8'h00, 0, 0, 0, 0);
    step("R10", 0, 8'h00, 0, 0, 8'h00, 0, 1, 0, 0);   // also R9: irq rises
    step("R4", 0, 8'h00, 1, 0, 8'h00, 0, 0, 0, 0);
    step("R6", 0, 8'h00, 0, 1, 8'h55, 0, 0, 0, 0);    // R9: both flags low, irq drops
    step("R7", 0, 8'h00, 0, 1, 8'h77, 0, 0, 0, 0);
    step("R2", 1, 8'h11, 0, 0, 8'h00, 0, 0, 0, 0);
    step("R11", 1, 8'h22, 0, 0, 8'h00, 0, 0, 0, 1);   // refusal beats clear
    step("R11", 0, 8'h00, 0, 0, 8'h00, 0, 0, 0, 1);
    step("R5", 1, 8'h99, 1, 0, 8'h00, 0, 0, 0, 0);
    step("R8", 0, 8'h00, 0, 0, 8'h00, 1, 0, 0, 0);
    step("R10", 0, 8'h00, 0, 0, 8'h00, 0, 1, 1, 0);   // clear wins
    step("R9", 0, 8'h00, 0, 0, 8'h00, 0, 1, 0, 0);
    step("R8", 0, 8'h00, 0, 0, 8'h00, 1, 0, 0, 0);    // accept while ready: no effect
    step("R6", 0, 8'h00, 0, 1, 8'h66, 0, 0, 0, 0);
    step("R7", 0, 8'h00, 0, 1, 8'h44, 1, 0, 0, 0);    // refused write with accept
    step("R4", 0, 8'h00, 1, 0, 8'h00, 0, 0, 0, 0);
    step("R4", 0, 8'h00, 1, 0, 8'h00, 0, 0, 0, 0);    // take when empty
    step("R2", 1, 8'h5A, 0, 0, 8'h00, 0, 0, 0, 1);
    step("R1", 0, 8'h00, 0, 0, 8'h00, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule